// File: doc/BRIEF.md
# PHY Reset and Clock Sequencer

This block owns a core-control word that carries four PHY-facing bits: a PHY reset, a PHY clock enable, a force-gated-clock override and a band-mode select. It moves those bits through two fixed two-step sequences. One sequence puts the PHY into reset and the other takes it out. Each step is one registered update of the word. A settle hold of `SETTLE_CYCLES` clock cycles follows every step. The other bits of the word are kept through every update, as a read-modify-write would keep them.

A controller starts a sequence with a single-cycle pulse on `enter_req` or `leave_req`. `busy` is high while the sequence runs. `done` pulses for one cycle when the last hold ends, and at that point the block is idle again. A separate request, `fclk_req` together with `fclk_on`, drives only the force-gated-clock bit and applies on the next clock edge. Requests of any kind that arrive while a sequence runs are dropped.

Top module: `phy_rst_seq`

## Requirements
- R1: On an accepted enter request, the next edge updates the word in one step: the reset bit (bit 2) is set, the force-gated-clock bit (bit 1) is set, the band-mode bit (bit 3) is cleared, and the clock-enable bit (bit 0) is unchanged.
- R2: When the first enter hold ends, one update clears only the force-gated-clock bit. A second hold follows, and the enter sequence then completes.
- R3: On an accepted leave request, the next edge updates the word in one step: the reset bit is cleared, the clock-enable bit is cleared, the force-gated-clock bit is set, and the band-mode bit is unchanged.
- R4: When the first leave hold ends, one update clears the force-gated-clock bit and sets the clock-enable bit. A final hold follows. The clock-enable bit rises only in this step.
- R5: Each step's value stays on the word for exactly SETTLE_CYCLES cycles before the next step or the end of the sequence.
- R6: `busy` is high from the edge that accepts a sequence until its final hold ends. `done` is then high for exactly one cycle, with `busy` low.
- R7: While `busy` is high, enter, leave and force-clock requests are ignored. The word changes only at the sequence's own steps.
- R8: A force-clock request in idle sets the force-gated-clock bit (`fclk_on`=1) or clears it (`fclk_on`=0) on the next edge. All other bits are unchanged, and neither `busy` nor `done` rises.
- R9: After synchronous reset the word equals CTRL_INIT with the reset bit and the force-gated-clock bit set and the clock-enable bit cleared. `busy` and `done` are low.
- R10: Bits other than the four named bits keep their CTRL_INIT value through every step.
- R11: When several requests arrive together in idle, enter takes priority over leave, and either sequence takes priority over a force-clock request, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | Start the enter-reset sequence (sampled when idle) |
| leave_req | input | 1 | Start the leave-reset sequence (sampled when idle) |
| fclk_req | input | 1 | Force-clock update request (sampled when idle) |
| fclk_on | input | 1 | Value for the force-gated-clock bit on a force-clock request |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |
| ctrl_word | output | CTRL_W | Registered core-control word |

## Verification
Some rules are checked by assertions on every clock cycle. These are the shape of the first step of each sequence, the limit that the clock enable rises only in the final leave step, the isolation of a force-clock update, the stability of the unnamed bits, and the one-cycle `done` pulse. The exact hold lengths, the value of the word after each second step, the dropping of requests that arrive mid-sequence, and the priority among simultaneous requests can only be shown by the bench. The bench follows the word cycle by cycle across randomly chosen sequences and injected noise and compares it with its own model.

// File: rtl/phy_rst_seq_pkg.sv
package phy_rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENT_A,
        ST_ENT_B,
        ST_LV_A,
        ST_LV_B
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ENTER_A,
        OP_ENTER_B,
        OP_LEAVE_A,
        OP_LEAVE_B,
        OP_FORCE_ON,
        OP_FORCE_OFF
    } step_op_e;

    // Per-bit edit requested by one step; set wins over nothing, clear over nothing.
    typedef struct packed {
        logic rst_set;
        logic rst_clr;
        logic clk_set;
        logic clk_clr;
        logic fgc_set;
        logic fgc_clr;
        logic band_clr;
    } bit_edit_t;

    function automatic bit_edit_t edit_for(step_op_e op);
        bit_edit_t e;
        e = '0;
        case (op)
            OP_ENTER_A: begin
                e.rst_set  = 1'b1;
                e.fgc_set  = 1'b1;
                e.band_clr = 1'b1;
            end
            OP_ENTER_B: e.fgc_clr = 1'b1;
            OP_LEAVE_A: begin
                e.rst_clr = 1'b1;
                e.clk_clr = 1'b1;
                e.fgc_set = 1'b1;
            end
            OP_LEAVE_B: begin
                e.fgc_clr = 1'b1;
                e.clk_set = 1'b1;
            end
            OP_FORCE_ON:  e.fgc_set = 1'b1;
            OP_FORCE_OFF: e.fgc_clr = 1'b1;
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/phy_rst_timer.sv
module phy_rst_timer #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign expire = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || arm || expire) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R5
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0) || $past(run)); // R5

endmodule

// File: rtl/phy_rst_fsm.sv
module phy_rst_fsm
    import phy_rst_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enter_req,
    input  logic     leave_req,
    input  logic     fclk_req,
    input  logic     fclk_on,
    input  logic     expire,
    output step_op_e op,
    output logic     arm,
    output logic     run,
    output logic     busy,
    output logic     done
);
    seq_state_e st, st_nxt;
    logic       done_nxt;

    always_comb begin
        st_nxt   = st;
        op       = OP_NONE;
        arm      = 1'b0;
        done_nxt = 1'b0;
        case (st)
            ST_IDLE: begin
                if (enter_req) begin
                    op     = OP_ENTER_A;
                    arm    = 1'b1;
                    st_nxt = ST_ENT_A;
                end else if (leave_req) begin
                    op     = OP_LEAVE_A;
                    arm    = 1'b1;
                    st_nxt = ST_LV_A;
                end else if (fclk_req) begin
                    op = fclk_on ? OP_FORCE_ON : OP_FORCE_OFF;
                end
            end
            ST_ENT_A: if (expire) begin
                op     = OP_ENTER_B;
                st_nxt = ST_ENT_B;
            end
            ST_LV_A: if (expire) begin
                op     = OP_LEAVE_B;
                st_nxt = ST_LV_B;
            end
            ST_ENT_B, ST_LV_B: if (expire) begin
                done_nxt = 1'b1;
                st_nxt   = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign run  = (st != ST_IDLE);
    assign busy = run;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            done <= 1'b0;
        end else begin
            st   <= st_nxt;
            done <= done_nxt;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R6
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !expire) |=> busy && $stable(st)); // R7

endmodule

// File: rtl/phy_rst_ctrlreg.sv
module phy_rst_ctrlreg
    import phy_rst_seq_pkg::*;
#(
    parameter int              CTRL_W    = 16,
    parameter int              CLKEN_POS = 0,
    parameter int              FGC_POS   = 1,
    parameter int              RST_POS   = 2,
    parameter int              BAND_POS  = 3,
    parameter logic [CTRL_W-1:0] CTRL_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  step_op_e          op,
    output logic [CTRL_W-1:0] q
);
    localparam logic [CTRL_W-1:0] ONE        = CTRL_W'(1);
    localparam logic [CTRL_W-1:0] NAMED_MASK = (ONE << CLKEN_POS) | (ONE << FGC_POS)
                                             | (ONE << RST_POS)   | (ONE << BAND_POS);
    localparam logic [CTRL_W-1:0] RESET_WORD = (CTRL_INIT & ~(ONE << CLKEN_POS))
                                             | (ONE << RST_POS) | (ONE << FGC_POS);

    bit_edit_t         e;
    logic [CTRL_W-1:0] d;

    always_comb begin
        e = edit_for(op);
        d = q;
        if (e.rst_set)  d[RST_POS]   = 1'b1;
        if (e.rst_clr)  d[RST_POS]   = 1'b0;
        if (e.clk_set)  d[CLKEN_POS] = 1'b1;
        if (e.clk_clr)  d[CLKEN_POS] = 1'b0;
        if (e.fgc_set)  d[FGC_POS]   = 1'b1;
        if (e.fgc_clr)  d[FGC_POS]   = 1'b0;
        if (e.band_clr) d[BAND_POS]  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_WORD;
        end else begin
            q <= d;
        end
    end

    AST_KEEP_OTHER: assert property (@(posedge clk) disable iff (rst)
        (q & ~NAMED_MASK) == (CTRL_INIT & ~NAMED_MASK)); // R10
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NONE) |=> $stable(q)); // R7

endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
    import phy_rst_seq_pkg::*;
#(
    parameter int                SETTLE_CYCLES = 16,
    parameter int                CTRL_W        = 16,
    parameter int                CLKEN_POS     = 0,
    parameter int                FGC_POS       = 1,
    parameter int                RST_POS       = 2,
    parameter int                BAND_POS      = 3,
    parameter logic [CTRL_W-1:0] CTRL_INIT     = 16'hA5A8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_req,
    input  logic              leave_req,
    input  logic              fclk_req,
    input  logic              fclk_on,
    output logic              busy,
    output logic              done,
    output logic [CTRL_W-1:0] ctrl_word
);
    localparam logic [CTRL_W-1:0] FGC_MASK = CTRL_W'(1) << FGC_POS;

    step_op_e op;
    logic     arm, run, expire;

    phy_rst_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm),
        .run    (run),
        .expire (expire)
    );

    phy_rst_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .enter_req (enter_req),
        .leave_req (leave_req),
        .fclk_req  (fclk_req),
        .fclk_on   (fclk_on),
        .expire    (expire),
        .op        (op),
        .arm       (arm),
        .run       (run),
        .busy      (busy),
        .done      (done)
    );

    phy_rst_ctrlreg #(
        .CTRL_W    (CTRL_W),
        .CLKEN_POS (CLKEN_POS),
        .FGC_POS   (FGC_POS),
        .RST_POS   (RST_POS),
        .BAND_POS  (BAND_POS),
        .CTRL_INIT (CTRL_INIT)
    ) u_reg (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .q   (ctrl_word)
    );

    AST_ENTER_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!busy && enter_req) |=> (busy && ctrl_word[RST_POS] && ctrl_word[FGC_POS]
            && !ctrl_word[BAND_POS] && ctrl_word[CLKEN_POS] == $past(ctrl_word[CLKEN_POS]))); // R1
    AST_LEAVE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!busy && !enter_req && leave_req) |=> (busy && !ctrl_word[RST_POS]
            && !ctrl_word[CLKEN_POS] && ctrl_word[FGC_POS]
            && ctrl_word[BAND_POS] == $past(ctrl_word[BAND_POS]))); // R3
    AST_CLKEN_LATE: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_word[CLKEN_POS]) |-> (busy && !ctrl_word[FGC_POS] && !ctrl_word[RST_POS])); // R4
    AST_FORCE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!busy && !enter_req && !leave_req && fclk_req) |=> (!busy
            && ctrl_word[FGC_POS] == $past(fclk_on)
            && (ctrl_word & ~FGC_MASK) == ($past(ctrl_word) & ~FGC_MASK))); // R8

endmodule

// File: tb/phy_rst_seq_test.sv
module phy_rst_seq_test;
    localparam int S = 16;
    localparam logic [15:0] INIT = 16'hA5A8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enter_req = 0, leave_req = 0, fclk_req = 0, fclk_on = 0;
    logic busy, done;
    logic [15:0] ctrl_word;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] exp_w;

    always #10 clk = ~clk;

    phy_rst_seq #(.SETTLE_CYCLES(S), .CTRL_W(16), .CTRL_INIT(INIT)) uut (
        .clk(clk), .rst(rst), .enter_req(enter_req), .leave_req(leave_req),
        .fclk_req(fclk_req), .fclk_on(fclk_on),
        .busy(busy), .done(done), .ctrl_word(ctrl_word)
    );

    // bit 0 clock enable, bit 1 force clock, bit 2 reset, bit 3 band mode
    function automatic logic [15:0] m_enter_a(logic [15:0] w);
        return (w | 16'h0006) & ~16'h0008;
    endfunction
    function automatic logic [15:0] m_enter_b(logic [15:0] w);
        return w & ~16'h0002;
    endfunction
    function automatic logic [15:0] m_leave_a(logic [15:0] w);
        return (w & ~16'h0005) | 16'h0002;
    endfunction
    function automatic logic [15:0] m_leave_b(logic [15:0] w);
        return (w & ~16'h0002) | 16'h0001;
    endfunction

    task automatic check(string req, logic [15:0] w, logic b, logic d);
        n_tests++;
        if (ctrl_word !== w || busy !== b || done !== d) begin
            n_fail++;
            $display("FAIL %s: word=%h busy=%b done=%b expected word=%h busy=%b done=%b",
                     req, ctrl_word, busy, done, w, b, d);
        end
    endtask

    task automatic clear_in();
        enter_req = 0; leave_req = 0; fclk_req = 0; fclk_on = 0;
    endtask

    // is_enter: which sequence; both: raise the other command too (R11); noise: inject while busy (R7)
    task automatic run_seq(bit is_enter, bit both, bit noise);
        logic [15:0] wa, wb;
        string ra, rb;
        wa = is_enter ? m_enter_a(exp_w) : m_leave_a(exp_w);
        wb = is_enter ? m_enter_b(wa) : m_leave_b(wa);
        ra = is_enter ? "R1" : "R3";
        rb = is_enter ? "R2" : "R4";
        if (is_enter) begin enter_req = 1; leave_req = both; end
        else leave_req = 1;
        fclk_req = both; fclk_on = ~exp_w[1];
        @(negedge clk);
        clear_in();
        check(both ? "R11" : ra, wa, 1'b1, 1'b0);
        for (int j = 1; j <= 2 * S; j++) begin
            if (noise) begin
                enter_req = 1'($urandom);
                leave_req = 1'($urandom);
                fclk_req  = 1'($urandom);
                fclk_on   = 1'($urandom);
            end
            @(negedge clk);
            clear_in();
            if (j < S)          check(noise ? "R7" : "R5", wa, 1'b1, 1'b0);
            else if (j < 2 * S) check(rb, wb, 1'b1, 1'b0);
            else                check("R6", wb, 1'b0, 1'b1);
        end
        @(negedge clk);
        check("R6", wb, 1'b0, 1'b0);
        exp_w = wb;
    endtask

    task automatic force_clk(bit on);
        fclk_req = 1; fclk_on = on;
        @(negedge clk);
        clear_in();
        exp_w = on ? (exp_w | 16'h0002) : (exp_w & ~16'h0002);
        check("R8", exp_w, 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        exp_w = (INIT & ~16'h0001) | 16'h0006;
        check("R9", exp_w, 1'b0, 1'b0);
        @(negedge clk);
        check("R9", exp_w, 1'b0, 1'b0);

        // directed corners
        run_seq(1'b0, 1'b0, 1'b0);   // leave from reset state
        force_clk(1'b1);
        force_clk(1'b0);
        run_seq(1'b1, 1'b0, 1'b0);   // enter
        run_seq(1'b1, 1'b1, 1'b0);   // enter with leave and force together: R11
        run_seq(1'b0, 1'b1, 1'b1);   // leave with force together and busy noise
        force_clk(1'b1);
        run_seq(1'b1, 1'b0, 1'b1);
        check("R10", exp_w, 1'b0, 1'b0);
        if ((ctrl_word & 16'hFFF0) !== (INIT & 16'hFFF0)) begin
            n_fail++;
            $display("FAIL R10: upper=%h expected=%h", ctrl_word & 16'hFFF0, INIT & 16'hFFF0);
        end
        n_tests++;

        // random mix
        for (int k = 0; k < 40; k++) begin
            int pick;
            pick = $urandom_range(0, 3);
            if (pick == 0)      run_seq(1'b1, 1'($urandom), 1'($urandom));
            else if (pick == 1) run_seq(1'b0, 1'($urandom), 1'($urandom));
            else                force_clk(1'($urandom));
        end

        // reset mid-sequence returns to reset word
        enter_req = 1;
        @(negedge clk);
        clear_in();
        repeat (3) @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        exp_w = (INIT & ~16'h0001) | 16'h0006;
        check("R9", exp_w, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #5_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule